// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block makes the stall and fetch-suppression decisions for an in-order five-stage integer pipeline. The stages are fetch, decode, execute, memory and writeback. Each cycle it compares the source register indexes of the instruction in decode with the destination indexes of the older instructions in execute and memory. It then decides whether the decoding instruction must wait. When it must wait, the program counter and the fetch/decode register hold, and an empty slot enters the decode/execute register in place of the instruction.

A mode input selects the operand-passing scheme of the surrounding datapath. In interlock-only mode there are no bypass paths. The register file writes early in the cycle and reads late, so only producers in execute and memory can block a consumer. In forwarding mode, results are bypassed from execute and memory. Only a load sitting in execute can block its direct consumer.

When a branch or jump-register leaves decode, fetch is suppressed until the datapath signals that the target is known. No wrong-path instruction enters decode during that time.

Top module: `pipe_interlock`

## Requirements
- R1: After reset, with no valid instruction in decode, all hold, bubble and flush outputs are low, and no fetch suppression is pending.
- R2: A producer stage creates a dependency only when its valid bit and its write enable are both high, its destination is nonzero, and that destination equals either decode source index. An instruction in decode whose valid bit is low never stalls.
- R3: With `fwd_en` = 0 (interlock-only), a dependency on execute or memory stalls decode. A consumer directly behind its producer therefore stalls exactly two cycles, and a consumer two slots behind stalls exactly one cycle. A load producer behaves the same way.
- R4: A producer that has reached writeback never causes a stall, in either mode.
- R5: With `fwd_en` = 1 (forwarding), the only stall is a dependency on execute while `ex_mem_rd` is high. A load followed at once by its consumer stalls exactly one cycle. A back-to-back ALU dependency, or a load two slots ahead, stalls zero cycles.
- R6: In every stall cycle, `pc_hold`, `ifid_hold` and `idex_bubble` are all high together.
- R7: In a stall cycle, the decode/execute entry outputs `idex_valid`, `idex_wen`, `idex_mem_rd` and `idex_mem_wr` are all low. In every other cycle they equal the decode inputs, each gated by `id_valid`.
- R8: In the cycle a valid control transfer leaves decode unstalled, `fetch_flush` and `pc_hold` are high. Both stay high in each following cycle until the cycle in which `ctl_resolved` is high, and in that cycle both are low.
- R9: A data stall has priority over a control transfer held in decode. That cycle has `ifid_hold` high and `fetch_flush` low, and suppression begins only when the transfer leaves decode. `fetch_flush` and `ifid_hold` are never high together.
- R10: Under these controls, every instruction of a program retires exactly once and in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1 = forwarding datapath, 0 = interlock-only |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_srcs | input | N_SRC*REG_W | Decode source indexes, source k in bits [k*REG_W +: REG_W] |
| id_wen | input | 1 | Decoded instruction writes a register |
| id_mem_rd | input | 1 | Decoded instruction reads memory |
| id_mem_wr | input | 1 | Decoded instruction writes memory |
| id_ctl | input | 1 | Decoded instruction is a branch or jump-register |
| ex_valid | input | 1 | Execute slot holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_mem_rd | input | 1 | Execute instruction is a load |
| ex_dst | input | REG_W | Execute destination index |
| mem_valid | input | 1 | Memory slot holds a real instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_dst | input | REG_W | Memory destination index |
| ctl_resolved | input | 1 | Strobe: the outstanding control transfer has its target |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load an empty slot into decode/execute |
| fetch_flush | output | 1 | Load an empty slot into fetch/decode |
| idex_valid | output | 1 | Next decode/execute valid bit |
| idex_wen | output | 1 | Next decode/execute register write enable |
| idex_mem_rd | output | 1 | Next decode/execute memory read enable |
| idex_mem_wr | output | 1 | Next decode/execute memory write enable |

## Verification
The bench builds the block with its defaults, REG_W = 5 and N_SRC = 2. This lets register 0 and the highest index 31 both appear in the programs, and puts a dependency on either the first or the second source within reach. A small pipeline model in the bench is steered only by the block's outputs. It runs short programs in both modes, counting stall and suppression cycles, and checks each count against the fixed value the rules give. It also checks that each program retires completely and in order.

// File: rtl/pil_pkg.sv
package pil_pkg;

    // Operand-passing scheme of the surrounding datapath
    typedef enum logic {
        MODE_INTERLOCK = 1'b0,
        MODE_FORWARD   = 1'b1
    } pass_mode_e;

    // Control bits loaded into the decode/execute register
    typedef struct packed {
        logic valid;
        logic wen;
        logic mem_rd;
        logic mem_wr;
    } idex_ctl_t;

    // State of the fetch-suppression tracker
    typedef struct packed {
        logic pend;
    } redir_st_t;

endpackage

// File: rtl/pil_src_match.sv
module pil_src_match #(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic                   prod_valid,
    input  logic                   prod_wen,
    input  logic [REG_W-1:0]       prod_dst,
    input  logic [N_SRC*REG_W-1:0] srcs,
    output logic                   hit
);
    localparam logic [REG_W-1:0] ZERO_IDX = '0;

    logic [N_SRC-1:0] src_eq;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_src
            assign src_eq[g] = (srcs[g*REG_W +: REG_W] == prod_dst);
        end
    endgenerate

    // index zero is hard-wired and never carries a result
    assign hit = prod_valid && prod_wen && (prod_dst != ZERO_IDX) && (|src_eq);

endmodule

// File: rtl/pil_redirect.sv
module pil_redirect
    import pil_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic resolved,
    output logic suppress
);
    redir_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (issue) begin
            st_d.pend = 1'b1;
        end else if (resolved) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign suppress = issue || (st_q.pend && !resolved);

    // R8
    pend_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolved && !issue) |=> !st_q.pend);

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
    import pil_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int N_SRC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fwd_en,
    input  logic                   id_valid,
    input  logic [N_SRC*REG_W-1:0] id_srcs,
    input  logic                   id_wen,
    input  logic                   id_mem_rd,
    input  logic                   id_mem_wr,
    input  logic                   id_ctl,
    input  logic                   ex_valid,
    input  logic                   ex_wen,
    input  logic                   ex_mem_rd,
    input  logic [REG_W-1:0]       ex_dst,
    input  logic                   mem_valid,
    input  logic                   mem_wen,
    input  logic [REG_W-1:0]       mem_dst,
    input  logic                   ctl_resolved,
    output logic                   pc_hold,
    output logic                   ifid_hold,
    output logic                   idex_bubble,
    output logic                   fetch_flush,
    output logic                   idex_valid,
    output logic                   idex_wen,
    output logic                   idex_mem_rd,
    output logic                   idex_mem_wr
);
    localparam int N_PROD = 2;     // producer stages that can block: execute, memory
    localparam int P_EX   = 0;
    localparam int P_MEM  = 1;

    pass_mode_e mode;
    assign mode = pass_mode_e'(fwd_en);

    logic [N_PROD-1:0]       prod_v;
    logic [N_PROD-1:0]       prod_w;
    logic [REG_W-1:0]        prod_dst [N_PROD];
    logic [N_PROD-1:0]       prod_hit;

    assign prod_v[P_EX]    = ex_valid;
    assign prod_w[P_EX]    = ex_wen;
    assign prod_dst[P_EX]  = ex_dst;
    assign prod_v[P_MEM]   = mem_valid;
    assign prod_w[P_MEM]   = mem_wen;
    assign prod_dst[P_MEM] = mem_dst;

    generate
        for (genvar p = 0; p < N_PROD; p++) begin : g_prod
            pil_src_match #(
                .REG_W (REG_W),
                .N_SRC (N_SRC)
            ) u_match (
                .prod_valid (prod_v[p]),
                .prod_wen   (prod_w[p]),
                .prod_dst   (prod_dst[p]),
                .srcs       (id_srcs),
                .hit        (prod_hit[p])
            );
        end
    endgenerate

    logic      data_stall;
    logic      ctl_issue;
    logic      suppress;
    idex_ctl_t idex_d;

    always_comb begin
        if (mode == MODE_FORWARD) begin
            // bypass covers everything except a load still in execute
            data_stall = id_valid && prod_hit[P_EX] && ex_mem_rd;
        end else begin
            // register file handles writeback; execute and memory must drain
            data_stall = id_valid && (|prod_hit);
        end
        ctl_issue = id_valid && id_ctl && !data_stall;
    end

    pil_redirect u_redirect (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (ctl_issue),
        .resolved (ctl_resolved),
        .suppress (suppress)
    );

    always_comb begin
        if (data_stall) begin
            idex_d = '0;
        end else begin
            idex_d.valid  = id_valid;
            idex_d.wen    = id_valid && id_wen;
            idex_d.mem_rd = id_valid && id_mem_rd;
            idex_d.mem_wr = id_valid && id_mem_wr;
        end
    end

    assign pc_hold     = data_stall || suppress;
    assign ifid_hold   = data_stall;
    assign idex_bubble = data_stall;
    assign fetch_flush = suppress && !data_stall;
    assign idex_valid  = idex_d.valid;
    assign idex_wen    = idex_d.wen;
    assign idex_mem_rd = idex_d.mem_rd;
    assign idex_mem_wr = idex_d.mem_wr;

    // R2
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !idex_bubble);

    // R5
    fwd_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && idex_bubble) |-> (ex_mem_rd && ex_valid));

    // R6
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> (pc_hold && ifid_hold));

    // R7
    bubble_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> !(idex_valid || idex_wen || idex_mem_rd || idex_mem_wr));

    // R8
    suppress_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_flush && !ctl_resolved) |=> (pc_hold || ctl_resolved));

    // R9
    flush_hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_flush && ifid_hold));

endmodule

// File: tb/pipe_interlock_bench.sv
module pipe_interlock_bench;
    localparam int RW = 5;
    localparam int NS = 2;

    typedef struct packed {
        logic          v;
        logic [RW-1:0] rd;
        logic [RW-1:0] rs1;
        logic [RW-1:0] rs2;
        logic          wen;
        logic          ld;
        logic          st;
        logic          ctl;
        logic [3:0]    tag;
    } ins_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n, fwd_en, id_valid, id_wen, id_mem_rd, id_mem_wr, id_ctl;
    logic [NS*RW-1:0] id_srcs;
    logic            ex_valid, ex_wen, ex_mem_rd, mem_valid, mem_wen, ctl_resolved;
    logic [RW-1:0]   ex_dst, mem_dst;
    logic            pc_hold, ifid_hold, idex_bubble, fetch_flush;
    logic            idex_valid, idex_wen, idex_mem_rd, idex_mem_wr;

    pipe_interlock #(.REG_W(RW), .N_SRC(NS)) u_pipe_interlock (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .id_valid(id_valid),
        .id_srcs(id_srcs), .id_wen(id_wen), .id_mem_rd(id_mem_rd),
        .id_mem_wr(id_mem_wr), .id_ctl(id_ctl), .ex_valid(ex_valid),
        .ex_wen(ex_wen), .ex_mem_rd(ex_mem_rd), .ex_dst(ex_dst),
        .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_dst(mem_dst),
        .ctl_resolved(ctl_resolved), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .idex_bubble(idex_bubble), .fetch_flush(fetch_flush),
        .idex_valid(idex_valid), .idex_wen(idex_wen),
        .idex_mem_rd(idex_mem_rd), .idex_mem_wr(idex_mem_wr)
    );

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    ins_t prog [8];
    int   plen;
    ins_t s_id, s_ex, s_mem, s_wb;
    bit   res_mem;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_ins(input int rd, input int rs1, input int rs2,
                           input bit wen, input bit ld, input bit st, input bit ctl);
        ins_t n;
        n.v = 1'b1; n.rd = RW'(rd); n.rs1 = RW'(rs1); n.rs2 = RW'(rs2);
        n.wen = wen; n.ld = ld; n.st = st; n.ctl = ctl; n.tag = 4'(plen);
        prog[plen] = n;
        plen++;
    endtask

    task automatic drive();
        id_valid  = s_id.v;
        id_srcs   = {s_id.rs2, s_id.rs1};
        id_wen    = s_id.wen;
        id_mem_rd = s_id.ld;
        id_mem_wr = s_id.st;
        id_ctl    = s_id.ctl;
        ex_valid  = s_ex.v;  ex_wen  = s_ex.wen;  ex_mem_rd = s_ex.ld; ex_dst = s_ex.rd;
        mem_valid = s_mem.v; mem_wen = s_mem.wen; mem_dst = s_mem.rd;
        ctl_resolved = res_mem ? (s_mem.v && s_mem.ctl) : (s_ex.v && s_ex.ctl);
    endtask

    task automatic do_reset();
        s_id = '0; s_ex = '0; s_mem = '0; s_wb = '0;
        rst_n = 1'b0;
        @(negedge clk); drive();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs the loaded program and checks stall and suppression counts
    task automatic run_prog(input string name, input string req, input bit fwd,
                            input bit rmem, input int exp_st, input int exp_fl);
        int pc = 0, stalls = 0, flushes = 0, ret = 0;
        int bad_idex = 0, overlap = 0, bad_hold = 0, bad_order = 0;
        fwd_en = fwd; res_mem = rmem;
        do_reset();
        for (int c = 0; c < 24; c++) begin
            bit   st;
            logic [3:0] exp_ix;
            @(negedge clk);
            drive();
            #1;
            st = idex_bubble;
            if (st) stalls++;
            if (fetch_flush) flushes++;
            if (fetch_flush && ifid_hold) overlap++;
            if (st && !(pc_hold && ifid_hold)) bad_hold++;
            exp_ix = st ? 4'b0 : {s_id.v, s_id.v & s_id.wen, s_id.v & s_id.ld, s_id.v & s_id.st};
            if ({idex_valid, idex_wen, idex_mem_rd, idex_mem_wr} != exp_ix) bad_idex++;
            if (s_wb.v) begin
                if (int'(s_wb.tag) != ret) bad_order++;
                ret++;
            end
            s_wb  = s_mem;
            s_mem = s_ex;
            s_ex  = st ? '0 : s_id;
            if (!ifid_hold) s_id = fetch_flush ? '0 : ((pc < plen) ? prog[pc] : '0);
            if (!pc_hold && pc < plen) pc++;
        end
        chk(stalls == exp_st, req, {name, " stall cycles"}, stalls, exp_st);
        chk(flushes == exp_fl, "R8", {name, " suppression cycles"}, flushes, exp_fl);
        chk(ret == plen, "R10", {name, " retired"}, ret, plen);
        chk(bad_order == 0, "R10", {name, " order errors"}, bad_order, 0);
        chk(bad_idex == 0, "R7", {name, " idex entry mismatches"}, bad_idex, 0);
        chk(bad_hold == 0, "R6", {name, " stall without holds"}, bad_hold, 0);
        chk(overlap == 0, "R9", {name, " flush with hold"}, overlap, 0);
        plen = 0;
    endtask

    task automatic t_reset();
        fwd_en = 1'b0; res_mem = 1'b0;
        do_reset();
        @(negedge clk); drive(); #1;
        chk({pc_hold, ifid_hold, idex_bubble, fetch_flush} == 4'b0, "R1",
            "reset outputs", int'({pc_hold, ifid_hold, idex_bubble, fetch_flush}), 0);
        chk({idex_valid, idex_wen, idex_mem_rd, idex_mem_wr} == 4'b0, "R1",
            "reset idex entry", int'({idex_valid, idex_wen, idex_mem_rd, idex_mem_wr}), 0);
    endtask

    // R3: adjacent producer/consumer, interlock-only
    task automatic t_nofwd_adjacent();
        add_ins(1, 2, 3, 1, 0, 0, 0);
        add_ins(4, 1, 5, 1, 0, 0, 0);
        run_prog("nofwd adjacent", "R3", 0, 0, 2, 0);
    endtask

    // R3: consumer two slots behind
    task automatic t_nofwd_dist2();
        add_ins(1, 2, 3, 1, 0, 0, 0);
        add_ins(9, 7, 8, 1, 0, 0, 0);
        add_ins(4, 1, 5, 1, 0, 0, 0);
        run_prog("nofwd distance two", "R3", 0, 0, 1, 0);
    endtask

    // R3 with a second-source dependency on index 31
    task automatic t_nofwd_src2();
        add_ins(31, 2, 3, 1, 0, 0, 0);
        add_ins(4, 6, 31, 0, 0, 1, 0);
        run_prog("nofwd second source", "R3", 0, 0, 2, 0);
    endtask

    // R3: load in interlock-only mode behaves like any producer
    task automatic t_nofwd_load();
        add_ins(6, 2, 0, 1, 1, 0, 0);
        add_ins(7, 6, 2, 1, 0, 0, 0);
        run_prog("nofwd load use", "R3", 0, 0, 2, 0);
    endtask

    // R4: producer three slots ahead sits in writeback
    task automatic t_wb_no_stall();
        add_ins(1, 2, 3, 1, 0, 0, 0);
        add_ins(9, 7, 8, 1, 0, 0, 0);
        add_ins(10, 7, 8, 1, 0, 0, 0);
        add_ins(4, 1, 5, 1, 0, 0, 0);
        run_prog("writeback producer", "R4", 0, 0, 0, 0);
    endtask

    // R5: forwarding cases
    task automatic t_fwd_cases();
        add_ins(1, 2, 3, 1, 0, 0, 0);
        add_ins(4, 1, 1, 1, 0, 0, 0);
        run_prog("fwd alu adjacent", "R5", 1, 0, 0, 0);
        add_ins(1, 2, 0, 1, 1, 0, 0);
        add_ins(4, 5, 1, 1, 0, 0, 0);
        run_prog("fwd load use", "R5", 1, 0, 1, 0);
        add_ins(1, 2, 0, 1, 1, 0, 0);
        add_ins(9, 7, 8, 1, 0, 0, 0);
        add_ins(4, 1, 5, 1, 0, 0, 0);
        run_prog("fwd load distance two", "R5", 1, 0, 0, 0);
    endtask

    // R2: index zero and non-writing producers create no dependency
    task automatic t_no_dep();
        add_ins(0, 2, 3, 1, 0, 0, 0);
        add_ins(4, 0, 0, 1, 0, 0, 0);
        run_prog("index zero", "R2", 0, 0, 0, 0);
        add_ins(1, 2, 3, 0, 0, 1, 0);
        add_ins(4, 1, 1, 1, 0, 0, 0);
        run_prog("producer write disabled", "R2", 0, 0, 0, 0);
    endtask

    // R8: control transfer suppression length
    task automatic t_branch();
        add_ins(0, 2, 3, 0, 0, 0, 1);
        add_ins(4, 5, 6, 1, 0, 0, 0);
        run_prog("branch resolved in execute", "R8", 0, 0, 0, 1);
        add_ins(0, 2, 3, 0, 0, 0, 1);
        add_ins(4, 5, 6, 1, 0, 0, 0);
        run_prog("branch resolved in memory", "R8", 0, 1, 0, 2);
    endtask

    // R9: data stall on a branch takes priority over suppression
    task automatic t_branch_dep();
        add_ins(1, 2, 3, 1, 0, 0, 0);
        add_ins(0, 1, 3, 0, 0, 0, 1);
        add_ins(4, 5, 6, 1, 0, 0, 0);
        run_prog("dependent branch", "R9", 0, 0, 2, 1);
    endtask

    initial begin
        plen = 0; rst_n = 1'b0; fwd_en = 1'b0; res_mem = 1'b0;
        s_id = '0; s_ex = '0; s_mem = '0; s_wb = '0;
        drive();
        t_reset();
        t_nofwd_adjacent();
        t_nofwd_dist2();
        t_nofwd_src2();
        t_nofwd_load();
        t_wb_no_stall();
        t_fwd_cases();
        t_no_dep();
        t_branch();
        t_branch_dep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule